// File: doc/BRIEF.md
# Scale Factor Replicating Packer

This block takes a stream of 128 per-row scale words, as read from a staging buffer, and writes them into a 128-lane scratchpad in a folded, replicated layout. Scale index r goes to lane r mod 32 of a 32-lane window, at column offset r/32 from a column base that the allocator supplies. The folded 32-lane image is written four times, once into each 32-lane window, at lane offsets 0, 32, 64 and 96. A reader confined to any one window therefore finds every scale locally.

Each accepted scale produces four scratchpad writes on consecutive cycles, one per window. The input is a valid/ready stream, and it is held off while replica writes are in flight. A commit input closes the current group of scales. Completion is reported through a done flag rather than a blocking wait, and the flag rises only once the group's final write has left the write port. A commit that arrives before all 128 scales have been received raises an error pulse instead.

Top module: `sfp_packer`

## Requirements
- R1: During and right after reset, in_ready is 1 and wr_en, done and err are 0.
- R2: The n-th scale accepted in a group (index r, counting from 0) is written with lane bits [4:0] equal to r mod 32 and with wr_col equal to col_base + r/32, where r/32 is index bits [6:5].
- R3: An accepted scale produces exactly four writes on the four cycles that follow the acceptance edge. They target lanes (r mod 32) + 0, +32, +64 and +96, in that order, and all four carry the same data and column.
- R4: in_ready is 0 while the first three replica writes of a scale are visible, so the next scale can be accepted no earlier than the edge that ends the fourth write.
- R5: col_base is sampled at the acceptance edge, and changing it while that scale's writes are in flight does not change their column.
- R6: Once 128 scales of a group have been accepted, in_ready stays 0 until a commit arrives.
- R7: A commit after 128 scales makes done rise one cycle after the later of the commit edge and the edge that ends the group's last write. in_ready stays 0 while that done is pending. done then stays 1 until the next scale is accepted.
- R8: A commit with fewer than 128 scales received (zero included) makes err 1 for the single cycle after the commit edge, with done remaining 0. The group count restarts, so the next scale is index 0.
- R9: After a complete group, each of the four 32-lane windows holds every one of the 128 scales exactly once, at lane (r mod 32) plus the window offset and column offset r/32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col_base | input | 9 | Allocated column base for the scale block |
| in_valid | input | 1 | Scale word offered |
| in_ready | output | 1 | Packer can take a scale this cycle |
| in_data | input | 32 | Scale word |
| commit | input | 1 | Closes the current group (one-cycle pulse) |
| wr_en | output | 1 | Scratchpad write strobe |
| wr_lane | output | 7 | Write lane (0 to 127) |
| wr_col | output | 9 | Write column |
| wr_data | output | 32 | Write data |
| done | output | 1 | Committed group fully written |
| err | output | 1 | Commit arrived before the group was full (one cycle) |

## Verification
A wrong replica counter shows up on the write port within four cycles of an acceptance, as a skipped, repeated or misordered window offset. It also shows up as in_ready coming back too early or too late. A wrong group counter stays hidden until a column offset or a fold lane comes out wrong, or until the commit, where err and done disagree with the number of scales sent. Shadowing all 512 writes per group exposes a mapping slip at the latest when the group closes. The early-commit and commit-during-replication cases expose a done that does not wait for the final write, within one cycle of that write.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int unsigned SFP_DATA_W    = 32;
  localparam int unsigned SFP_NUM_SCALE = 128;
  localparam int unsigned SFP_WIN_LANES = 32;
  localparam int unsigned SFP_REPLICAS  = 4;
  localparam int unsigned SFP_COL_W     = 9;

  function automatic int unsigned sfp_lane_bits(input int unsigned win, input int unsigned reps);
    return $clog2(win * reps);
  endfunction
endpackage

// File: rtl/sfp_fold.sv
module sfp_fold #(
  parameter int unsigned IDX_W = 7,
  parameter int unsigned WIN_W = 5,
  parameter int unsigned COL_W = 9
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [COL_W-1:0] col_base,
  output logic [WIN_W-1:0] lane_in_win,
  output logic [COL_W-1:0] col
);
  // low index bits pick the lane inside a window, high bits the column step
  always_comb begin
    lane_in_win = idx[WIN_W-1:0];
    col         = col_base + COL_W'(idx >> WIN_W);
  end
endmodule

// File: rtl/sfp_replicator.sv
module sfp_replicator #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned WIN_LANES = 32,
  parameter int unsigned REPLICAS  = 4,
  parameter int unsigned COL_W     = 9,
  localparam int unsigned WIN_W    = $clog2(WIN_LANES),
  localparam int unsigned REP_W    = $clog2(REPLICAS),
  localparam int unsigned LANE_W   = WIN_W + REP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic [DATA_W-1:0] in_data,
  input  logic [WIN_W-1:0]  in_lane,
  input  logic [COL_W-1:0]  in_col,
  output logic              busy,
  output logic              wr_en,
  output logic [LANE_W-1:0] wr_lane,
  output logic [COL_W-1:0]  wr_col,
  output logic [DATA_W-1:0] wr_data
);
  localparam logic [REP_W-1:0] LAST_REP = REP_W'(REPLICAS - 1);

  logic [REP_W-1:0]  rep;
  logic [DATA_W-1:0] hold_data;
  logic [WIN_W-1:0]  hold_lane;
  logic [COL_W-1:0]  hold_col;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      rep       <= '0;
      wr_en     <= 1'b0;
      wr_lane   <= '0;
      wr_col    <= '0;
      wr_data   <= '0;
      hold_data <= '0;
      hold_lane <= '0;
      hold_col  <= '0;
    end else if (acc) begin
      // replica 0 goes out right away, the rest follow from the hold registers
      hold_data <= in_data;
      hold_lane <= in_lane;
      hold_col  <= in_col;
      wr_en     <= 1'b1;
      wr_lane   <= {REP_W'(0), in_lane};
      wr_col    <= in_col;
      wr_data   <= in_data;
      rep       <= REP_W'(1);
      busy      <= 1'b1;
    end else if (busy) begin
      wr_en   <= 1'b1;
      wr_lane <= {rep, hold_lane};
      wr_col  <= hold_col;
      wr_data <= hold_data;
      rep     <= rep + REP_W'(1);
      if (rep == LAST_REP) busy <= 1'b0;
    end else begin
      wr_en <= 1'b0;
    end
  end

  assert_start_window0_R3: assert property (@(posedge clk) disable iff (rst)
    acc |=> (wr_en && wr_lane[LANE_W-1:WIN_W] == '0));

  assert_next_replica_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_lane[LANE_W-1:WIN_W] != LAST_REP) |=>
      (wr_en && wr_lane == $past(wr_lane) + LANE_W'(WIN_LANES)
       && $stable(wr_data) && $stable(wr_col)));
endmodule

// File: rtl/sfp_tracker.sv
module sfp_tracker #(
  parameter int unsigned NUM_SCALES = 128,
  localparam int unsigned CNT_W     = $clog2(NUM_SCALES + 1),
  localparam int unsigned IDX_W     = $clog2(NUM_SCALES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             commit,
  input  logic             repl_busy,
  output logic [IDX_W-1:0] idx,
  output logic             full,
  output logic             pend,
  output logic             done,
  output logic             err
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_SCALES);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cnt_nxt;
  logic             commit_ok;

  always_comb begin
    cnt_nxt   = count + CNT_W'(acc);
    commit_ok = commit && (cnt_nxt == FULL_CNT);
    idx       = count[IDX_W-1:0];
    full      = (count == FULL_CNT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      pend  <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      count <= commit ? '0 : cnt_nxt;
      err   <= commit && !commit_ok;
      if (acc) done <= 1'b0;
      // done waits until the replicator has no write left for this group
      if ((pend || commit_ok) && !repl_busy && !acc) begin
        done <= 1'b1;
        pend <= 1'b0;
      end else if (commit_ok) begin
        pend <= 1'b1;
      end
    end
  end

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  assert_err_from_commit_R8: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(commit));
endmodule

// File: rtl/sfp_packer.sv
module sfp_packer
  import sfp_pkg::*;
#(
  parameter int unsigned DATA_W     = SFP_DATA_W,
  parameter int unsigned NUM_SCALES = SFP_NUM_SCALE,
  parameter int unsigned WIN_LANES  = SFP_WIN_LANES,
  parameter int unsigned REPLICAS   = SFP_REPLICAS,
  parameter int unsigned COL_W      = SFP_COL_W,
  localparam int unsigned WIN_W     = $clog2(WIN_LANES),
  localparam int unsigned REP_W     = $clog2(REPLICAS),
  localparam int unsigned LANE_W    = sfp_lane_bits(WIN_LANES, REPLICAS),
  localparam int unsigned IDX_W     = $clog2(NUM_SCALES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COL_W-1:0]  col_base,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              commit,
  output logic              wr_en,
  output logic [LANE_W-1:0] wr_lane,
  output logic [COL_W-1:0]  wr_col,
  output logic [DATA_W-1:0] wr_data,
  output logic              done,
  output logic              err
);
  logic             acc;
  logic             busy;
  logic             full;
  logic             pend;
  logic [IDX_W-1:0] idx;
  logic [WIN_W-1:0] fold_lane;
  logic [COL_W-1:0] fold_col;

  assign in_ready = !busy && !full && !pend;
  assign acc      = in_valid && in_ready;

  sfp_tracker #(.NUM_SCALES(NUM_SCALES)) u_track (
    .clk(clk), .rst(rst), .acc(acc), .commit(commit), .repl_busy(busy),
    .idx(idx), .full(full), .pend(pend), .done(done), .err(err)
  );

  sfp_fold #(.IDX_W(IDX_W), .WIN_W(WIN_W), .COL_W(COL_W)) u_fold (
    .idx(idx), .col_base(col_base), .lane_in_win(fold_lane), .col(fold_col)
  );

  sfp_replicator #(
    .DATA_W(DATA_W), .WIN_LANES(WIN_LANES), .REPLICAS(REPLICAS), .COL_W(COL_W)
  ) u_repl (
    .clk(clk), .rst(rst), .acc(acc), .in_data(in_data), .in_lane(fold_lane),
    .in_col(fold_col), .busy(busy), .wr_en(wr_en), .wr_lane(wr_lane),
    .wr_col(wr_col), .wr_data(wr_data)
  );

  assert_hold_off_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_lane[LANE_W-1:WIN_W] != REP_W'(REPLICAS - 1)) |-> !in_ready);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_en);
endmodule

// File: tb/sfp_packer_tb.sv
module sfp_packer_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [8:0]  col_base;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        commit;
  logic        wr_en;
  logic [6:0]  wr_lane;
  logic [8:0]  wr_col;
  logic [31:0] wr_data;
  logic        done;
  logic        err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;
  logic [8:0]  grp_base;
  logic [31:0] exp_data [128];
  int          hits [128][4];
  logic [31:0] sdat [128][4];
  logic [6:0]  first_lane;
  logic [8:0]  first_col;

  always #10 clk = ~clk;

  sfp_packer u_dut (
    .clk(clk), .rst(rst), .col_base(col_base), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .commit(commit), .wr_en(wr_en),
    .wr_lane(wr_lane), .wr_col(wr_col), .wr_data(wr_data), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      chk(0, "WATCHDOG", "run did not end", 64'(cyc), 64'd100000);
      summary();
    end
  end

  task automatic clear_shadow();
    for (int l = 0; l < 128; l++)
      for (int c = 0; c < 4; c++) begin
        hits[l][c] = 0;
        sdat[l][c] = '0;
      end
  endtask

  // checks the four writes of scale index r; ends at the negedge showing the last one
  task automatic send(input logic [31:0] d, input int r, input bit twist);
    @(negedge clk);
    in_data  = d;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    exp_data[r] = d;
    if (twist) col_base = grp_base ^ 9'h0a5;
    first_lane = wr_lane;
    first_col  = wr_col;
    for (int k = 0; k < 4; k++) begin
      chk(wr_en, "R3", "write strobe", 64'(wr_en), 64'd1);
      chk(wr_lane == 7'(k * 32 + r % 32), "R3", "replica lane", 64'(wr_lane), 64'(k * 32 + r % 32));
      chk(wr_col == grp_base + 9'(r / 32), twist ? "R5" : "R2", "column", 64'(wr_col), 64'(grp_base + 9'(r / 32)));
      chk(wr_data == d, "R3", "data", 64'(wr_data), 64'(d));
      if (wr_en && wr_col - grp_base < 4) begin
        hits[wr_lane][wr_col - grp_base]++;
        sdat[wr_lane][wr_col - grp_base] = wr_data;
      end
      if (k < 3) begin
        chk(!in_ready, "R4", "ready during replicas", 64'(in_ready), 64'd0);
        @(negedge clk);
      end
    end
    col_base = grp_base;
  endtask

  task automatic gap();
    repeat ($urandom_range(0, 3)) @(negedge clk);
  endtask

  task automatic check_windows();
    for (int w = 0; w < 4; w++) begin
      int bad = 0;
      for (int l = 0; l < 32; l++)
        for (int c = 0; c < 4; c++)
          if (hits[w * 32 + l][c] != 1 || sdat[w * 32 + l][c] != exp_data[c * 32 + l]) bad++;
      chk(bad == 0, "R9", $sformatf("window %0d mismatches", w), 64'(bad), 64'd0);
    end
  endtask

  task automatic pulse_commit();
    @(negedge clk);
    commit = 1'b1;
    @(posedge clk);
    @(negedge clk);
    commit = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5ca1e));
    rst = 1'b1; in_valid = 1'b0; in_data = '0; commit = 1'b0;
    grp_base = 9'd16; col_base = 9'd16;
    clear_shadow();
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R1", "ready in reset", 64'(in_ready), 64'd1);
    chk(wr_en == 1'b0, "R1", "wr_en in reset", 64'(wr_en), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!wr_en && !done && !err && in_ready, "R1", "idle after reset",
        64'({wr_en, done, err, in_ready}), 64'b0001);

    // group A: full group, idle commit
    for (int r = 0; r < 128; r++) begin
      gap();
      send($urandom, r, r == 5);
    end
    chk(!in_ready, "R6", "ready after 128 scales", 64'(in_ready), 64'd0);
    repeat (3) @(negedge clk);
    chk(!in_ready, "R6", "ready still held", 64'(in_ready), 64'd0);
    pulse_commit();
    chk(done, "R7", "done after idle commit", 64'(done), 64'd1);
    chk(!err, "R8", "no error on full commit", 64'(err), 64'd0);
    repeat (2) @(negedge clk);
    chk(done, "R7", "done held", 64'(done), 64'd1);
    check_windows();

    // premature commit after 10 scales
    for (int r = 0; r < 10; r++) send($urandom, r, 0);
    chk(!done, "R7", "done cleared by acceptance", 64'(done), 64'd0);
    pulse_commit();
    chk(err && !done, "R8", "early commit", 64'({err, done}), 64'b10);
    @(negedge clk);
    chk(!err, "R8", "err one cycle", 64'(err), 64'd0);
    pulse_commit();
    chk(err, "R8", "empty commit", 64'(err), 64'd1);

    // group B: commit while the last scale is still replicating
    grp_base = 9'd300; col_base = 9'd300;
    clear_shadow();
    send($urandom, 0, 0);
    chk(first_lane == 7'd0 && first_col == 9'd300, "R8", "index restarts",
        64'({first_lane, first_col}), 64'({7'd0, 9'd300}));
    for (int r = 1; r < 127; r++) begin
      gap();
      send($urandom, r, 0);
    end
    @(negedge clk);
    in_data = $urandom; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    commit = 1'b1;
    exp_data[127] = in_data;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) begin
        @(negedge clk);
        commit = 1'b0;
        chk(!done, "R7", $sformatf("done early at replica %0d", k), 64'(done), 64'd0);
        chk(!in_ready, "R7", "ready while done pending", 64'(in_ready), 64'd0);
      end
      chk(wr_en && wr_lane == 7'(k * 32 + 31) && wr_col == 9'd303, "R3", "last scale write",
          64'({wr_en, wr_lane, wr_col}), 64'({1'b1, 7'(k * 32 + 31), 9'd303}));
      hits[wr_lane][wr_col - grp_base]++;
      sdat[wr_lane][wr_col - grp_base] = wr_data;
    end
    @(negedge clk);
    chk(done && !err, "R7", "done after last write", 64'({done, err}), 64'b10);
    check_windows();
    send($urandom, 0, 0);
    chk(!done, "R7", "done cleared by next scale", 64'(done), 64'd0);

    summary();
  end
endmodule